// File: doc/BRIEF.md
# Spread-Spectrum PWM Timebase

This block produces the switching-cycle timing for a fixed-frequency, peak-current-mode power controller. A counter running on the system clock measures out each switching cycle. The length of each cycle is taken from a sweep register. That register follows a triangular profile around the nominal period, so the switching energy is spread over neighbouring frequencies instead of being concentrated in sharp harmonics. The defaults give a 60 kHz nominal rate from a 50 MHz clock: 833 clocks, swept by ±56 clocks one clock per cycle, which is about a ±4 kHz deviation repeating at roughly 270 Hz.

At the start of every cycle the block raises a one-clock cycle-start strobe for other blocks and, in the same clock, the gate-on request. The gate then stays high until one of two events. The first is the duty cap, three quarters of the current period by default. The second is a terminate request from the analog current comparators, arriving asynchronously. Terminate requests are synchronised through a two-stage flop chain. A request that appears during the blanking window is remembered and takes effect as soon as the minimum on-time (24 clocks, 480 ns at 50 MHz) has passed. A hold-off input keeps the gate low while the cycle strobe and the sweep keep running.

The gate is controlled by a three-state machine. GS_IDLE means the gate is low. GS_BLANK means the gate is high and the minimum on-time is still running. GS_CONDUCT means the gate is high and may be terminated. The transitions are:
- *start* (GS_IDLE, GS_BLANK or GS_CONDUCT to GS_BLANK): taken at the cycle wrap while hold-off is low.
- *unblank* (GS_BLANK to GS_CONDUCT): taken when the minimum on-time has elapsed with no request pending and the cap not reached.
- *early-stop* (GS_BLANK to GS_IDLE): taken at the end of blanking when a request is pending or the cap is already reached.
- *stop* (GS_CONDUCT to GS_IDLE): taken on a synchronised request or on reaching the cap.
- *force-off* (any state to GS_IDLE): taken whenever hold-off is high.

Top module: `ss_pwm_timebase`

## Requirements
- R1: While rst_n is low, gate_on_o and cycle_start_o are both 0.
- R2: cycle_start_o is a single-clock pulse. The first pulse appears NOM_PERIOD clocks after reset release. Each later pulse follows the previous one by the current period. At every pulse the period changes by exactly SWEEP_STEP.
- R3: The period sweeps as a triangle. Starting at NOM_PERIOD it rises by SWEEP_STEP per cycle. When a further rise would pass NOM_PERIOD+SWEEP_DEV it falls instead. When a further fall would pass below NOM_PERIOD-SWEEP_DEV it rises instead. It never leaves that range.
- R4: When hold_off_i is low at the cycle wrap, gate_on_o rises in the same clock in which cycle_start_o is high. The gate never rises in any other clock.
- R5: A gate pulse lasts at most floor(P*DUTY_NUM/2^DUTY_SHIFT) clocks, where P is the current period. With no terminate request it lasts exactly that long.
- R6: Unless hold-off cuts it, a gate pulse lasts at least MIN_ON_CLKS clocks. A terminate request seen during that window ends the pulse after exactly MIN_ON_CLKS clocks.
- R7: A terminate request raised during the t-th high clock of a pulse (t past blanking) and held ends the pulse after t+2 high clocks, because it passes through a two-flop synchroniser.
- R8: Once a terminate request has ended a pulse, the gate stays low for the rest of the cycle, even if the request is removed.
- R9: While hold_off_i is high the gate stays low from the next clock on. The cycle-start pulses and the period sweep continue unchanged.
- R10: If hold_off_i rises during a pulse, the gate falls in the next clock. If hold_off_i is released mid-cycle, the gate does not rise again before the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_off_i | input | 1 | Keeps the gate low; the timebase keeps running |
| term_req_i | input | 1 | Asynchronous cycle-terminate request from the current comparators |
| gate_on_o | output | 1 | Gate-on request to the driver |
| cycle_start_o | output | 1 | One-clock strobe at each switching-cycle start |

## Verification
The bench goes after the sweep turning points. A design that reverses one step late or early would produce periods outside the ±SWEEP_DEV window, or repeat an extreme value. It drives terminate requests that land inside the blanking window, right after it, and as single-clock pulses. A design that drops the deferred request, ignores the synchroniser latency or lets the gate rise again after a released request would show pulse lengths different from MIN_ON_CLKS, t+2 or a single run. Hold-off is applied across whole cycles, mid-pulse and released mid-cycle, to catch a strobe that stops with the gate, a gate that lingers for an extra clock, or a gate that restarts before the next cycle start.

// File: rtl/ss_pwm_pkg.sv
`timescale 1ns/1ps
package ss_pwm_pkg;

    // Gate control states
    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,   // gate low, waiting for the next cycle start
        GS_BLANK   = 2'd1,   // gate high, minimum on-time still running
        GS_CONDUCT = 2'd2    // gate high, terminate requests accepted
    } gate_state_e;

endpackage

// File: rtl/ss_pwm_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the asynchronous terminate request.
module ss_pwm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_q <= 1'b0;
                else        q_q <= d_i;
            end
            assign q_o = q_q;
        end else begin : g_chain
            logic [STAGES-1:0] sr_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], d_i};
            end
            assign q_o = sr_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ss_pwm_sweep.sv
`timescale 1ns/1ps
// Triangular period sweep: one step per cycle, reverses at the window edges.
module ss_pwm_sweep #(
    parameter int unsigned NOM  = 833,
    parameter int unsigned DEV  = 56,
    parameter int unsigned STEP = 1,
    parameter int unsigned PW   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    output logic [PW-1:0] period_o
);
    localparam int unsigned PER_HI = NOM + DEV;
    localparam int unsigned PER_LO = NOM - DEV;
    localparam logic [PW:0] HI_X   = (PW+1)'(PER_HI);
    localparam logic [PW:0] LO_X   = (PW+1)'(PER_LO + STEP);
    localparam logic [PW:0] STEP_X = (PW+1)'(STEP);

    logic [PW-1:0] per_q;
    assign period_o = per_q;

    generate
        if (DEV == 0 || STEP == 0) begin : g_fixed
            // No sweep: period pinned to nominal
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) per_q <= PW'(NOM);
                else        per_q <= PW'(NOM);
            end
            logic unused_adv;
            assign unused_adv = adv_i;
        end else begin : g_tri
            logic          up_q, up_n;
            logic [PW-1:0] per_n;
            logic [PW:0]   per_x, raise_x, lower_x;

            assign per_x   = {1'b0, per_q};
            assign raise_x = per_x + STEP_X;
            assign lower_x = per_x - STEP_X;

            always_comb begin
                per_n = per_q;
                up_n  = up_q;
                if (up_q) begin
                    if (raise_x <= HI_X) begin
                        per_n = raise_x[PW-1:0];
                    end else begin
                        per_n = lower_x[PW-1:0];
                        up_n  = 1'b0;
                    end
                end else begin
                    if (per_x >= LO_X) begin
                        per_n = lower_x[PW-1:0];
                    end else begin
                        per_n = raise_x[PW-1:0];
                        up_n  = 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    per_q <= PW'(NOM);
                    up_q  <= 1'b1;
                end else if (adv_i) begin
                    per_q <= per_n;
                    up_q  <= up_n;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ss_pwm_period.sv
`timescale 1ns/1ps
// Cycle counter: wraps after period_i clocks and flags the cycle start.
module ss_pwm_period #(
    parameter int unsigned PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    output logic          wrap_o,
    output logic          start_o
);
    logic [PW-1:0] cnt_q;
    logic          start_q;

    assign wrap_o  = (cnt_q == period_i - PW'(1));
    assign start_o = start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            cnt_q   <= wrap_o ? '0 : cnt_q + PW'(1);
            start_q <= wrap_o;
        end
    end
endmodule

// File: rtl/ss_pwm_gate.sv
`timescale 1ns/1ps
// Gate control state machine: blanking, conduction, duty cap, hold-off.
module ss_pwm_gate
    import ss_pwm_pkg::*;
#(
    parameter int unsigned PW         = 10,
    parameter int unsigned MIN_ON     = 24,
    parameter int unsigned DUTY_NUM   = 3,
    parameter int unsigned DUTY_SHIFT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_i,
    input  logic          hold_i,
    input  logic          term_i,
    input  logic [PW-1:0] period_i,
    output logic          gate_o
);
    localparam int unsigned MW       = PW + $clog2(DUTY_NUM + 1);
    localparam logic [PW-1:0] MIN_ON_V = PW'(MIN_ON);

    gate_state_e   st_q, st_n;
    logic [PW-1:0] ton_q, ton_n;
    logic          pend_q, pend_n;
    logic [MW-1:0] prod;
    logic [PW-1:0] cap;

    // Duty cap in clocks for the current period
    assign prod = MW'(period_i) * MW'(DUTY_NUM);
    assign cap  = PW'(prod >> DUTY_SHIFT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= GS_IDLE;
            ton_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            ton_q  <= ton_n;
            pend_q <= pend_n;
        end
    end

    // Next-state logic
    always_comb begin
        st_n   = st_q;
        ton_n  = ton_q;
        pend_n = pend_q;
        if (hold_i) begin
            st_n = GS_IDLE;                       // force-off
        end else if (wrap_i) begin
            st_n   = GS_BLANK;                    // start
            ton_n  = PW'(1);
            pend_n = 1'b0;
        end else begin
            unique case (st_q)
                GS_IDLE: begin
                    st_n = GS_IDLE;
                end
                GS_BLANK: begin
                    if (ton_q < MIN_ON_V) begin
                        pend_n = pend_q | term_i;  // defer request
                        ton_n  = ton_q + PW'(1);
                    end else if (pend_q || term_i || ton_q >= cap) begin
                        st_n = GS_IDLE;            // early-stop
                    end else begin
                        st_n  = GS_CONDUCT;        // unblank
                        ton_n = ton_q + PW'(1);
                    end
                end
                GS_CONDUCT: begin
                    if (term_i || ton_q >= cap) begin
                        st_n = GS_IDLE;            // stop
                    end else begin
                        ton_n = ton_q + PW'(1);
                    end
                end
                default: begin
                    st_n = GS_IDLE;
                end
            endcase
        end
    end

    // Output
    always_comb begin
        gate_o = (st_q != GS_IDLE);
    end
endmodule

// File: rtl/ss_pwm_timebase.sv
`timescale 1ns/1ps
// Spread-spectrum PWM timebase top level.
module ss_pwm_timebase #(
    parameter int unsigned NOM_PERIOD  = 833,  // clocks per nominal cycle
    parameter int unsigned SWEEP_DEV   = 56,   // peak period deviation, clocks
    parameter int unsigned SWEEP_STEP  = 1,    // period change per cycle
    parameter int unsigned MIN_ON_CLKS = 24,   // blanking / minimum on-time
    parameter int unsigned DUTY_NUM    = 3,    // duty cap numerator
    parameter int unsigned DUTY_SHIFT  = 2,    // duty cap denominator = 2^shift
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_off_i,
    input  logic term_req_i,
    output logic gate_on_o,
    output logic cycle_start_o
);
    localparam int unsigned PER_HI = NOM_PERIOD + SWEEP_DEV;
    localparam int unsigned PW     = $clog2(PER_HI + 1);

    logic [PW-1:0] cur_period;
    logic          wrap;
    logic          term_s;

    ss_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (term_req_i),
        .q_o   (term_s)
    );

    ss_pwm_sweep #(
        .NOM  (NOM_PERIOD),
        .DEV  (SWEEP_DEV),
        .STEP (SWEEP_STEP),
        .PW   (PW)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (wrap),
        .period_o (cur_period)
    );

    ss_pwm_period #(.PW(PW)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (cur_period),
        .wrap_o   (wrap),
        .start_o  (cycle_start_o)
    );

    ss_pwm_gate #(
        .PW         (PW),
        .MIN_ON     (MIN_ON_CLKS),
        .DUTY_NUM   (DUTY_NUM),
        .DUTY_SHIFT (DUTY_SHIFT)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap),
        .hold_i   (hold_off_i),
        .term_i   (term_s),
        .period_i (cur_period),
        .gate_o   (gate_on_o)
    );
endmodule

// File: rtl/ss_pwm_timebase_chk.sv
`timescale 1ns/1ps
// Property checker for ss_pwm_timebase, attached by bind below.
module ss_pwm_timebase_chk #(
    parameter int unsigned NOM        = 833,
    parameter int unsigned DEV        = 56,
    parameter int unsigned STEP       = 1,
    parameter int unsigned MIN_ON     = 24,
    parameter int unsigned DUTY_NUM   = 3,
    parameter int unsigned DUTY_SHIFT = 2,
    parameter int unsigned PW         = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold_off_i,
    input logic          gate_o,
    input logic          start_o,
    input logic [PW-1:0] period
);
    logic [31:0] hi_run;
    logic [31:0] per_w;
    logic [31:0] cap_c;

    assign per_w = 32'(period);
    assign cap_c = (per_w * DUTY_NUM) >> DUTY_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_run <= '0;
        else if (gate_o) hi_run <= hi_run + 32'd1;
        else             hi_run <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!gate_o && !start_o));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    assert_period_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (period != $past(period)) |->
            (start_o && ((per_w == 32'($past(period)) + STEP) ||
                         (per_w + STEP == 32'($past(period))))));

    assert_period_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_w <= NOM + DEV) && (per_w >= NOM - DEV));

    assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> start_o);

    assert_start_drives_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !$past(hold_off_i)) |-> gate_o);

    assert_duty_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (hi_run < cap_c));

    assert_min_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_o) && !$past(hold_off_i)) |-> (hi_run >= MIN_ON));

    assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off_i |=> !gate_o);
endmodule

bind ss_pwm_timebase ss_pwm_timebase_chk #(
    .NOM        (NOM_PERIOD),
    .DEV        (SWEEP_DEV),
    .STEP       (SWEEP_STEP),
    .MIN_ON     (MIN_ON_CLKS),
    .DUTY_NUM   (DUTY_NUM),
    .DUTY_SHIFT (DUTY_SHIFT),
    .PW         (PW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_off_i (hold_off_i),
    .gate_o     (gate_on_o),
    .start_o    (cycle_start_o),
    .period     (cur_period)
);

// File: tb/ss_pwm_timebase_bench.sv
`timescale 1ns/1ps
module ss_pwm_timebase_bench;
    localparam int NOM = 40, DEV = 6, STEP = 2, MIN_ON = 5, DN = 3, DS = 2;

    logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, term = 1'b0;
    logic gate, strobe;
    int   checks = 0, fails = 0, gk = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    ss_pwm_timebase #(
        .NOM_PERIOD(NOM), .SWEEP_DEV(DEV), .SWEEP_STEP(STEP),
        .MIN_ON_CLKS(MIN_ON), .DUTY_NUM(DN), .DUTY_SHIFT(DS), .SYNC_STAGES(2)
    ) u_ss_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .hold_off_i(hold), .term_req_i(term),
        .gate_on_o(gate), .cycle_start_o(strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int cap_of(int len);
        return (len * DN) >> DS;
    endfunction

    // Expected period of cycle k (k=0 is the first cycle after reset)
    function automatic int exp_len(int k);
        int l = NOM;
        bit up = 1'b1;
        for (int i = 0; i < k; i++) begin
            if (up) begin
                if (l + STEP <= NOM + DEV) l += STEP;
                else begin l -= STEP; up = 1'b0; end
            end else begin
                if (l - STEP >= NOM - DEV) l -= STEP;
                else begin l += STEP; up = 1'b1; end
            end
        end
        return l;
    endfunction

    // Behavioural reference model, advanced on every rising edge
    int m_pos, m_k, m_t;
    bit m_on, m_pend, m_start, m_s1, m_s2;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_k = 0; m_on = 0; m_t = 0; m_pend = 0;
            m_start = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int len;
            bit wr, ts;
            len = exp_len(m_k);
            wr  = (m_pos == len - 1);
            ts  = m_s2;
            if (hold) m_on = 0;
            else if (wr) begin m_on = 1; m_t = 1; m_pend = 0; end
            else if (m_on) begin
                if (m_t < MIN_ON) begin m_pend = m_pend | ts; m_t++; end
                else if (m_pend || ts || m_t >= cap_of(len)) m_on = 0;
                else m_t++;
            end
            if (wr) begin m_pos = 0; m_k++; end
            else m_pos++;
            m_start = wr;
            m_s2 = m_s1;
            m_s1 = term;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(gate == m_on, "R4/R5/R6/R7/R8/R9/R10 gate vs model", int'(gate), int'(m_on));
            chk(strobe == m_start, "R2/R3 strobe vs model", int'(strobe), int'(m_start));
        end
    end

    // Runs one cycle from a strobe-seen negedge to the next one.
    // term high for clocks [tf,tt), hold high for clocks [df,dt); clock 1 = strobe clock.
    task automatic run_cycle(input int tf, input int tt, input int df, input int dt,
                             output int hi, output int ln, output bit g1);
        int idx = 1;
        hi = 0;
        g1 = gate;
        while (1) begin
            if (gate) hi++;
            term = (idx >= tf && idx < tt);
            hold = (idx >= df && idx < dt);
            @(negedge clk);
            idx++;
            if (strobe) break;
        end
        ln = idx - 1;
        gk++;
    endtask

    initial begin
        int hi, ln, gap, mx, mn, e;
        bit g1;
        mx = 0; mn = 1000;
        repeat (4) begin
            @(negedge clk);
            chk(gate == 0, "R1 gate in reset", int'(gate), 0);
            chk(strobe == 0, "R1 strobe in reset", int'(strobe), 0);
        end
        rst_n = 1'b1;
        gap = 0;
        while (1) begin
            @(negedge clk);
            gap++;
            if (strobe) break;
        end
        chk(gap == NOM, "R2 first strobe after reset", gap, NOM);
        gk = 1;

        // Free-running cycles through both sweep extremes
        for (int i = 0; i < 12; i++) begin
            e = exp_len(gk);
            run_cycle(0, 0, 0, 0, hi, ln, g1);
            chk(ln == e, "R2 cycle length", ln, e);
            chk(hi == cap_of(ln), "R5 uncut pulse at duty cap", hi, cap_of(ln));
            chk(g1 == 1, "R4 gate high with strobe", int'(g1), 1);
            if (ln > mx) mx = ln;
            if (ln < mn) mn = ln;
        end
        chk(mx == NOM + DEV, "R3 sweep top", mx, NOM + DEV);
        chk(mn == NOM - DEV, "R3 sweep bottom", mn, NOM - DEV);

        // Request during blanking: deferred to the minimum on-time
        run_cycle(1, 20, 0, 0, hi, ln, g1);
        chk(hi == MIN_ON, "R6 deferred terminate", hi, MIN_ON);
        e = exp_len(gk);
        run_cycle(0, 0, 0, 0, hi, ln, g1);
        chk(hi == cap_of(e), "R6 next cycle uncut", hi, cap_of(e));

        // Held request after blanking: two-clock synchroniser latency
        run_cycle(10, 28, 0, 0, hi, ln, g1);
        chk(hi == 12, "R7 terminate latency", hi, 12);

        // One-clock request: gate stays off afterwards
        run_cycle(10, 11, 0, 0, hi, ln, g1);
        chk(hi == 12, "R8 no re-rise after short request", hi, 12);

        // Hold-off mid-pulse, released mid-cycle
        run_cycle(0, 0, 8, 20, hi, ln, g1);
        chk(hi == 8, "R10 hold-off cuts and no restart", hi, 8);

        // Hold-off across whole cycles
        e = exp_len(gk);
        run_cycle(0, 0, e, 1000, hi, ln, g1);
        chk(hi == cap_of(e), "R9 cycle before hold-off", hi, cap_of(e));
        for (int i = 0; i < 2; i++) begin
            e = exp_len(gk);
            run_cycle(0, 0, 0, 1000, hi, ln, g1);
            chk(hi == 0, "R9 gate low under hold-off", hi, 0);
            chk(ln == e, "R9 strobe keeps sweeping", ln, e);
        end
        e = exp_len(gk);
        run_cycle(0, 0, 0, e, hi, ln, g1);
        chk(hi == 0, "R9 last held cycle", hi, 0);
        chk(ln == e, "R9 last held length", ln, e);
        e = exp_len(gk);
        run_cycle(0, 0, 0, 0, hi, ln, g1);
        chk(g1 == 1 && hi == cap_of(e), "R9 gate resumes after release", hi, cap_of(e));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule